// File: doc/BRIEF.md
# Convolution Output-Tile Engine

The engine computes one spatial output tile of a convolution layer from data that already sits in on-chip memories. An array of TM lanes works in parallel, each lane a TN-wide signed dot product feeding an accumulator bank that holds every pixel of the tile. Each clock the sequencer presents one kernel tap for one output pixel to three read ports: input tile, weights and biases. All TM×TN products of that tap are summed into the accumulators. The first input-channel group seeds each accumulator with its channel's bias. The final tap of the last input-channel group applies a rectifier.

When all taps of an output-channel group are accumulated, a drain stage streams the tile out. Each beat carries TM saturated results for one pixel on a valid/ready interface. Back-pressure is honoured without limit: `out_valid` and `out_data` hold until `out_ready` is seen. No further accumulation begins until the last beat of the group is accepted. The next output-channel group then starts. After the final group a single-cycle `done` pulse follows.

The three read ports have a fixed one-cycle latency and no stall. The surrounding logic must return data in the cycle after `mem_rd_en` is high, for the address presented with it.

Top module: `conv_tile_engine`

## Requirements
- R1: During and after reset, `out_valid`, `done` and `mem_rd_en` are low until a job is started.
- R2: A `start` pulse while idle begins a job. A `start` pulse while a job is in progress has no effect: no additional beats and no additional `done` pulse are produced.
- R3: Taps are visited with loops nested from outer to inner as: output-channel group mg, input-channel group ng, tile row r, tile column c, kernel row i, kernel column j.
- R3 (input port addressing): input address = ng·IN_ROWS·IN_COLS + (S·r+i)·IN_COLS + (S·c+j), where IN_ROWS = (TR−1)·S+K and IN_COLS = (TC−1)·S+K. Bits [tn·DW +: DW] of the returned word hold channel ng·TN+tn.
- R3 (weight and bias addressing): weight address = ((mg·NG+ng)·K+i)·K+j. Bits [(tm·TN+tn)·WW +: WW] hold the weight from input channel ng·TN+tn to output channel mg·TM+tm. Bias address = mg, and bits [tm·BW +: BW] hold the bias of channel mg·TM+tm.
- R4: For the first input-channel group, each accumulator starts from its channel's bias rather than from its previous value.
- R5: Each result equals bias + Σ over all input channels and kernel taps of weight × input, using signed two's-complement arithmetic for all values.
- R6: A result is clamped to zero only when it is negative after the last tap of the last input-channel group. Negative partial sums at earlier steps are kept.
- R7: Results are saturated to the signed OW-bit range when streamed out.
- R8: For each output-channel group, TR·TC beats leave in row-major pixel order. Bits [tm·OW +: OW] of a beat carry channel mg·TM+tm. While `out_valid` is high and `out_ready` low, `out_valid` and `out_data` remain unchanged.
- R9: `done` is a one-cycle pulse issued two cycles after the last beat of the last group is accepted. Memory reads never occur while a beat is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job when idle |
| mem_rd_en | output | 1 | Read strobe shared by the three read ports |
| in_rd_addr | output | IA_W | Input tile word address |
| in_rd_data | input | TN·DW | TN input channels at one position |
| w_rd_addr | output | WA_W | Weight word address |
| w_rd_data | input | TM·TN·WW | All weights of one tap |
| b_rd_addr | output | BA_W | Bias word address |
| b_rd_data | input | TM·BW | Biases of one output-channel group |
| out_valid | output | 1 | Result beat available |
| out_ready | input | 1 | Sink accepts the beat |
| out_data | output | TM·OW | TM saturated results for one pixel |
| done | output | 1 | Job finished pulse |

## Verification
The assertions assume that read data arrives exactly one cycle after the strobe. They also assume memory contents stay fixed while a job runs, and that the sink may withhold `out_ready` for any length of time. The bench models the three memories as registered reads, rewrites their contents only between jobs, and drives `out_ready` from a random pattern with roughly one stall in four. Values are bounded so that no accumulator exceeds its 24-bit range. Results exceeding the output range are produced only by a dedicated saturation case.

// File: rtl/conv_tile_pkg.sv
package conv_tile_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FLUSH, PH_DRAIN} phase_e;

  function automatic int wbits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/conv_tile_lane.sv
module conv_tile_lane #(
  parameter int TN = 2,
  parameter int DW = 8,
  parameter int WW = 8,
  parameter int AW = 24
) (
  input  logic [TN*WW-1:0] w_vec,
  input  logic [TN*DW-1:0] x_vec,
  output logic [AW-1:0]    dot
);
  localparam int PW = DW + WW;

  logic signed [PW-1:0] prod [TN];
  logic signed [AW-1:0] total;

  for (genvar tn = 0; tn < TN; tn++) begin : g_mul
    logic signed [PW-1:0] wa;
    logic signed [PW-1:0] xa;
    assign wa = PW'($signed(w_vec[tn*WW +: WW]));
    assign xa = PW'($signed(x_vec[tn*DW +: DW]));
    assign prod[tn] = wa * xa;
  end

  always_comb begin
    total = '0;
    for (int t = 0; t < TN; t++) total = total + AW'(prod[t]);
  end

  assign dot = total;
endmodule

// File: rtl/conv_tile_seq.sv
module conv_tile_seq
  import conv_tile_pkg::*;
#(
  parameter int MG      = 2,
  parameter int NG      = 2,
  parameter int TR      = 3,
  parameter int TC      = 3,
  parameter int K       = 3,
  parameter int S       = 1,
  parameter int IN_ROWS = 5,
  parameter int IN_COLS = 5,
  parameter int IA_W    = 6,
  parameter int WA_W    = 6,
  parameter int BA_W    = 1,
  parameter int PX_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            drain_fin,
  output logic            rd_en,
  output logic [IA_W-1:0] in_addr,
  output logic [WA_W-1:0] w_addr,
  output logic [BA_W-1:0] b_addr,
  output logic            p_vld,
  output logic [PX_W-1:0] p_pix,
  output logic            p_first,
  output logic            p_last,
  output logic            drain_go,
  output logic            done
);
  localparam int NG_W = wbits(NG);
  localparam int R_W  = wbits(TR);
  localparam int C_W  = wbits(TC);
  localparam int K_W  = wbits(K);

  phase_e          ph;
  logic [BA_W-1:0] mg;
  logic [NG_W-1:0] ng;
  logic [R_W-1:0]  r;
  logic [C_W-1:0]  c;
  logic [K_W-1:0]  i;
  logic [K_W-1:0]  j;

  logic j_end, i_end, c_end, r_end, ng_end, mg_end;
  assign j_end  = (int'(j)  == K - 1);
  assign i_end  = (int'(i)  == K - 1);
  assign c_end  = (int'(c)  == TC - 1);
  assign r_end  = (int'(r)  == TR - 1);
  assign ng_end = (int'(ng) == NG - 1);
  assign mg_end = (int'(mg) == MG - 1);

  assign rd_en   = (ph == PH_RUN);
  assign in_addr = IA_W'(int'(ng) * (IN_ROWS * IN_COLS)
                       + (S * int'(r) + int'(i)) * IN_COLS
                       + S * int'(c) + int'(j));
  assign w_addr  = WA_W'(((int'(mg) * NG + int'(ng)) * K + int'(i)) * K + int'(j));
  assign b_addr  = mg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; mg <= '0; ng <= '0; r <= '0; c <= '0; i <= '0; j <= '0;
      drain_go <= 1'b0; done <= 1'b0;
    end else begin
      done     <= 1'b0;
      drain_go <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph <= PH_RUN; mg <= '0; ng <= '0; r <= '0; c <= '0; i <= '0; j <= '0;
          end
        end
        PH_RUN: begin
          if (j_end) begin
            j <= '0;
            if (i_end) begin
              i <= '0;
              if (c_end) begin
                c <= '0;
                if (r_end) begin
                  r <= '0;
                  if (ng_end) begin
                    ng <= '0;
                    ph <= PH_FLUSH;
                  end else ng <= ng + 1'b1;
                end else r <= r + 1'b1;
              end else c <= c + 1'b1;
            end else i <= i + 1'b1;
          end else j <= j + 1'b1;
        end
        PH_FLUSH: begin
          ph       <= PH_DRAIN;
          drain_go <= 1'b1;
        end
        PH_DRAIN: begin
          if (drain_fin) begin
            if (mg_end) begin
              ph   <= PH_IDLE;
              done <= 1'b1;
            end else begin
              mg <= mg + 1'b1;
              ph <= PH_RUN;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_vld <= 1'b0; p_pix <= '0; p_first <= 1'b0; p_last <= 1'b0;
    end else begin
      p_vld   <= (ph == PH_RUN);
      p_pix   <= PX_W'(int'(r) * TC + int'(c));
      p_first <= (ng == '0) && (i == '0) && (j == '0);
      p_last  <= ng_end && i_end && j_end;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_TAP_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (p_vld && p_last) |-> !p_first || (NG == 1 && K == 1)); // R6
endmodule

// File: rtl/conv_tile_accbank.sv
module conv_tile_accbank #(
  parameter int TM   = 2,
  parameter int PIX  = 9,
  parameter int PX_W = 4,
  parameter int AW   = 24,
  parameter int BW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               p_vld,
  input  logic [PX_W-1:0]    p_pix,
  input  logic               p_first,
  input  logic               p_last,
  input  logic [TM*AW-1:0]   dot_bus,
  input  logic [TM*BW-1:0]   bias_bus,
  input  logic [PX_W-1:0]    rd_pix,
  input  logic               rd_active,
  output logic [TM*AW-1:0]   rd_row
);
  logic signed [AW-1:0] acc [PIX][TM];
  logic signed [AW-1:0] nxt [TM];

  always_comb begin
    for (int t = 0; t < TM; t++) begin
      logic signed [AW-1:0] base;
      base = p_first ? AW'($signed(bias_bus[t*BW +: BW])) : acc[p_pix][t];
      nxt[t] = base + $signed(dot_bus[t*AW +: AW]);
      if (p_last && nxt[t][AW-1]) nxt[t] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < PIX; p++)
        for (int t = 0; t < TM; t++) acc[p][t] <= '0;
    end else if (p_vld) begin
      for (int t = 0; t < TM; t++) acc[p_pix][t] <= nxt[t];
    end
  end

  logic neg_any;
  always_comb begin
    neg_any = 1'b0;
    for (int t = 0; t < TM; t++) begin
      rd_row[t*AW +: AW] = acc[rd_pix][t];
      neg_any = neg_any | acc[rd_pix][t][AW-1];
    end
  end

  AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> !neg_any); // R6
  AST_NO_WRITE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> !p_vld); // R9
endmodule

// File: rtl/conv_tile_drain.sv
module conv_tile_drain #(
  parameter int TM   = 2,
  parameter int PIX  = 9,
  parameter int PX_W = 4,
  parameter int AW   = 24,
  parameter int OW   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [TM*AW-1:0] acc_row,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [TM*OW-1:0] out_data,
  output logic [PX_W-1:0]  rd_pix,
  output logic             fin
);
  localparam logic signed [AW-1:0] O_MAX = AW'((2 ** (OW - 1)) - 1);
  localparam logic signed [AW-1:0] O_MIN = AW'(-(2 ** (OW - 1)));

  always_comb begin
    for (int t = 0; t < TM; t++) begin
      logic signed [AW-1:0] a;
      a = $signed(acc_row[t*AW +: AW]);
      if (a > O_MAX)      out_data[t*OW +: OW] = OW'(O_MAX);
      else if (a < O_MIN) out_data[t*OW +: OW] = OW'(O_MIN);
      else                out_data[t*OW +: OW] = OW'(a);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; rd_pix <= '0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        out_valid <= 1'b1;
        rd_pix    <= '0;
      end else if (out_valid && out_ready) begin
        if (int'(rd_pix) == PIX - 1) begin
          out_valid <= 1'b0;
          fin       <= 1'b1;
        end else rd_pix <= rd_pix + 1'b1;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
endmodule

// File: rtl/conv_tile_engine.sv
module conv_tile_engine
  import conv_tile_pkg::*;
#(
  parameter int M_CH = 4,
  parameter int N_CH = 4,
  parameter int TM   = 2,
  parameter int TN   = 2,
  parameter int TR   = 3,
  parameter int TC   = 3,
  parameter int K    = 3,
  parameter int S    = 1,
  parameter int DW   = 8,
  parameter int WW   = 8,
  parameter int BW   = 16,
  parameter int AW   = 24,
  parameter int OW   = 12,
  localparam int MG       = M_CH / TM,
  localparam int NG       = N_CH / TN,
  localparam int IN_ROWS  = (TR - 1) * S + K,
  localparam int IN_COLS  = (TC - 1) * S + K,
  localparam int PIX      = TR * TC,
  localparam int IN_DEPTH = NG * IN_ROWS * IN_COLS,
  localparam int W_DEPTH  = MG * NG * K * K,
  localparam int IA_W     = wbits(IN_DEPTH),
  localparam int WA_W     = wbits(W_DEPTH),
  localparam int BA_W     = wbits(MG),
  localparam int PX_W     = wbits(PIX)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  mem_rd_en,
  output logic [IA_W-1:0]       in_rd_addr,
  input  logic [TN*DW-1:0]      in_rd_data,
  output logic [WA_W-1:0]       w_rd_addr,
  input  logic [TM*TN*WW-1:0]   w_rd_data,
  output logic [BA_W-1:0]       b_rd_addr,
  input  logic [TM*BW-1:0]      b_rd_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [TM*OW-1:0]      out_data,
  output logic                  done
);
  logic            p_vld, p_first, p_last, drain_go, drain_fin;
  logic [PX_W-1:0] p_pix, rd_pix;
  logic [TM*AW-1:0] dot_bus, acc_row;

  conv_tile_seq #(
    .MG(MG), .NG(NG), .TR(TR), .TC(TC), .K(K), .S(S),
    .IN_ROWS(IN_ROWS), .IN_COLS(IN_COLS),
    .IA_W(IA_W), .WA_W(WA_W), .BA_W(BA_W), .PX_W(PX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .drain_fin(drain_fin),
    .rd_en(mem_rd_en), .in_addr(in_rd_addr), .w_addr(w_rd_addr), .b_addr(b_rd_addr),
    .p_vld(p_vld), .p_pix(p_pix), .p_first(p_first), .p_last(p_last),
    .drain_go(drain_go), .done(done)
  );

  for (genvar tm = 0; tm < TM; tm++) begin : g_lane
    conv_tile_lane #(.TN(TN), .DW(DW), .WW(WW), .AW(AW)) u_lane (
      .w_vec(w_rd_data[tm*TN*WW +: TN*WW]),
      .x_vec(in_rd_data),
      .dot(dot_bus[tm*AW +: AW])
    );
  end

  conv_tile_accbank #(.TM(TM), .PIX(PIX), .PX_W(PX_W), .AW(AW), .BW(BW)) u_acc (
    .clk(clk), .rst_n(rst_n), .p_vld(p_vld), .p_pix(p_pix), .p_first(p_first),
    .p_last(p_last), .dot_bus(dot_bus), .bias_bus(b_rd_data),
    .rd_pix(rd_pix), .rd_active(out_valid), .rd_row(acc_row)
  );

  conv_tile_drain #(.TM(TM), .PIX(PIX), .PX_W(PX_W), .AW(AW), .OW(OW)) u_drain (
    .clk(clk), .rst_n(rst_n), .go(drain_go), .acc_row(acc_row),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .rd_pix(rd_pix), .fin(drain_fin)
  );

  AST_RD_NOT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !out_valid); // R9
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready, 2)); // R9
endmodule

// File: tb/conv_tile_engine_tb_top.sv
module conv_tile_engine_tb_top;
  import conv_tile_pkg::*;

  localparam int M_CH = 4, N_CH = 4, TM = 2, TN = 2, TR = 3, TC = 3, K = 3, S = 1;
  localparam int DW = 8, WW = 8, BW = 16, AW = 24, OW = 12;
  localparam int MG = M_CH / TM, NG = N_CH / TN;
  localparam int IN_ROWS = (TR - 1) * S + K, IN_COLS = (TC - 1) * S + K;
  localparam int IN_DEPTH = NG * IN_ROWS * IN_COLS, W_DEPTH = MG * NG * K * K;
  localparam int IA_W = wbits(IN_DEPTH), WA_W = wbits(W_DEPTH), BA_W = wbits(MG);
  localparam int OMAX = 2 ** (OW - 1) - 1;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic mem_rd_en, out_valid, done;
  logic [IA_W-1:0] in_rd_addr;
  logic [WA_W-1:0] w_rd_addr;
  logic [BA_W-1:0] b_rd_addr;
  logic [TN*DW-1:0] in_rd_data;
  logic [TM*TN*WW-1:0] w_rd_data;
  logic [TM*BW-1:0] b_rd_data;
  logic [TM*OW-1:0] out_data;

  always #10 clk = ~clk;

  conv_tile_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rd_en(mem_rd_en),
    .in_rd_addr(in_rd_addr), .in_rd_data(in_rd_data),
    .w_rd_addr(w_rd_addr), .w_rd_data(w_rd_data),
    .b_rd_addr(b_rd_addr), .b_rd_data(b_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
  );

  int xin [N_CH][IN_ROWS][IN_COLS];
  int wt  [M_CH][N_CH][K][K];
  int bs  [M_CH];
  logic [TN*DW-1:0]    in_mem [IN_DEPTH];
  logic [TM*TN*WW-1:0] w_mem  [W_DEPTH];
  logic [TM*BW-1:0]    b_mem  [MG];

  always_ff @(posedge clk) begin
    if (mem_rd_en) begin
      in_rd_data <= in_mem[in_rd_addr];
      w_rd_data  <= w_mem[w_rd_addr];
      b_rd_data  <= b_mem[b_rd_addr];
    end
  end

  int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0;
  bit bp_en = 1'b0;
  logic [TM*OW-1:0] exp_q [$];
  string tag_q [$];

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on every accepted beat
  always @(negedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      summary_and_end();
    end
    out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
    if (rst_n && out_valid && out_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected beat: actual %h expected none", out_data);
      end else begin
        logic [TM*OW-1:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (out_data !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", tg, out_data, e);
        end
      end
    end
    if (rst_n && done) begin
      done_cnt++;
      chk(exp_q.size() == 0, "R9 done only after last beat", exp_q.size(), 0);
    end
  end

  function automatic int ref_val(int m, int r, int c);
    int a = bs[m];
    for (int n = 0; n < N_CH; n++)
      for (int i = 0; i < K; i++)
        for (int j = 0; j < K; j++)
          a += wt[m][n][i][j] * xin[n][S*r+i][S*c+j];
    if (a < 0) a = 0;
    if (a > OMAX) a = OMAX;
    return a;
  endfunction

  task automatic pack_and_expect(input string tag);
    for (int ng = 0; ng < NG; ng++)
      for (int rr = 0; rr < IN_ROWS; rr++)
        for (int cc = 0; cc < IN_COLS; cc++)
          for (int tn = 0; tn < TN; tn++)
            in_mem[ng*IN_ROWS*IN_COLS + rr*IN_COLS + cc][tn*DW +: DW] = DW'(xin[ng*TN+tn][rr][cc]);
    for (int mg = 0; mg < MG; mg++) begin
      for (int tm = 0; tm < TM; tm++) b_mem[mg][tm*BW +: BW] = BW'(bs[mg*TM+tm]);
      for (int ng = 0; ng < NG; ng++)
        for (int i = 0; i < K; i++)
          for (int j = 0; j < K; j++)
            for (int tm = 0; tm < TM; tm++)
              for (int tn = 0; tn < TN; tn++)
                w_mem[((mg*NG+ng)*K+i)*K+j][(tm*TN+tn)*WW +: WW] =
                  WW'(wt[mg*TM+tm][ng*TN+tn][i][j]);
    end
    for (int mg = 0; mg < MG; mg++)
      for (int r = 0; r < TR; r++)
        for (int c = 0; c < TC; c++) begin
          logic [TM*OW-1:0] e;
          for (int tm = 0; tm < TM; tm++) e[tm*OW +: OW] = OW'(ref_val(mg*TM+tm, r, c));
          exp_q.push_back(e);
          tag_q.push_back(tag);
        end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_job(input string tag, input bit extra_start);
    int tgt;
    pack_and_expect(tag);
    tgt = done_cnt + 1;
    pulse_start();
    if (extra_start) begin
      repeat (40) @(negedge clk);
      pulse_start();
    end
    while (done_cnt < tgt) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(done_cnt == tgt, {tag, " R2 R9 one done per job"}, done_cnt, tgt);
    chk(exp_q.size() == 0 && !out_valid, {tag, " R8 all beats delivered"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(mem_rd_en == 1'b0, "R1 mem_rd_en in reset", mem_rd_en, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && mem_rd_en == 1'b0, "R1 idle after reset", out_valid, 0);

    // Job 1: random small data, back-pressure, start while busy (R2 R3 R5 R8)
    bp_en = 1'b1;
    for (int n = 0; n < N_CH; n++)
      for (int rr = 0; rr < IN_ROWS; rr++)
        for (int cc = 0; cc < IN_COLS; cc++) xin[n][rr][cc] = int'($urandom_range(15)) - 8;
    for (int m = 0; m < M_CH; m++) begin
      bs[m] = int'($urandom_range(100)) - 50;
      for (int n = 0; n < N_CH; n++)
        for (int i = 0; i < K; i++)
          for (int j = 0; j < K; j++) wt[m][n][i][j] = int'($urandom_range(15)) - 8;
    end
    run_job("R3/R5 random taps", 1'b1);

    // Job 2: zero weights, result is bias only (R4)
    for (int m = 0; m < M_CH; m++) begin
      for (int n = 0; n < N_CH; n++)
        for (int i = 0; i < K; i++)
          for (int j = 0; j < K; j++) wt[m][n][i][j] = 0;
    end
    bs[0] = 37; bs[1] = -21; bs[2] = 5; bs[3] = 1000;
    run_job("R4 bias seed", 1'b0);

    // Job 3: first group drives partial sum negative, second lifts it (R6)
    bp_en = 1'b0;
    for (int m = 0; m < M_CH; m++) begin
      bs[m] = 0;
      for (int n = 0; n < N_CH; n++)
        for (int i = 0; i < K; i++)
          for (int j = 0; j < K; j++) wt[m][n][i][j] = (n < TN) ? -3 : 4;
    end
    for (int n = 0; n < N_CH; n++)
      for (int rr = 0; rr < IN_ROWS; rr++)
        for (int cc = 0; cc < IN_COLS; cc++) xin[n][rr][cc] = 5;
    run_job("R6 negative partial kept", 1'b0);

    // Job 4: negative final result clamps to zero (R6)
    bp_en = 1'b1;
    for (int m = 0; m < M_CH; m++) begin
      bs[m] = 10;
      for (int n = 0; n < N_CH; n++)
        for (int i = 0; i < K; i++)
          for (int j = 0; j < K; j++) wt[m][n][i][j] = -2;
    end
    run_job("R6 final clamp", 1'b0);

    // Job 5: large values saturate (R7)
    for (int m = 0; m < M_CH; m++) begin
      bs[m] = 0;
      for (int n = 0; n < N_CH; n++)
        for (int i = 0; i < K; i++)
          for (int j = 0; j < K; j++) wt[m][n][i][j] = 100;
    end
    for (int n = 0; n < N_CH; n++)
      for (int rr = 0; rr < IN_ROWS; rr++)
        for (int cc = 0; cc < IN_COLS; cc++) xin[n][rr][cc] = 100;
    run_job("R7 saturation", 1'b0);

    summary_and_end();
  end
endmodule